// File: doc/BRIEF.md
# Radio Link Search and Hop Synchronizer

This block brings up and keeps alive a point-to-point radio link between two endpoints that share a table of hopping channels. One endpoint has the master role and the other the slave role, set by a role input. After reset both start in the locate phase. The master sends one search packet on a channel, waits a fixed window for an acknowledge, and then moves to the next channel. The slave listens on each channel for longer than the master needs to sweep every channel. This means a search packet reaches the slave on any channel that is free.

The two endpoints then move to the sync phase. In this phase the master alone sends a start packet. The start packet carries a countdown in hop slots, and both sides count it down and enter the idle phase together. In the idle phase the channel index advances once per hop slot, starting from the channel on which the link was found. If no packet arrives from the peer for a run of hop slots, the endpoint drops back to the locate phase.

Packets leave through a valid/ready request port and arrive as single-cycle receive pulses that carry a kind code. The block outputs the channel index into the shared table. Deriving the table and running the radio are done outside this block.

Top module: `linkSeek`

## Requirements
- R1: While reset is held and on the first cycle after it, the phase output is locate (code 0) and the channel index is 0. A master requests a search packet (kind 0); a slave requests nothing.
- R2: In locate, a master sends exactly one search packet per channel. After each accepted packet it waits ACK_WAIT cycles, then moves to the next channel, wrapping from NUM_CHAN-1 to 0. Accepted searches are therefore ACK_WAIT+1 cycles apart when ready is held high. A request and its channel stay stable until they are accepted.
- R3: In locate, a slave stays on each channel for SLAVE_DWELL cycles. At elaboration, SLAVE_DWELL must be larger than NUM_CHAN*(ACK_WAIT+1).
- R4: When a slave in locate receives a search packet (kind 0), it requests one acknowledge (kind 1) on the same channel. It holds that request until it is accepted and then enters sync (code 1). Other kinds received in this state are ignored.
- R5: A master that receives an acknowledge (kind 1) during its wait window enters sync and keeps the current channel. Other kinds are ignored.
- R6: In sync, a master requests a start packet (kind 2) with countdown START_SLOTS. It enters idle (code 2) exactly START_SLOTS*SLOT_LEN cycles after the start packet is accepted.
- R7: In sync, a slave that receives a start packet loads its count field. It enters idle count*SLOT_LEN cycles later. A count of 0 puts it in idle on the next cycle.
- R8: In idle, the channel index starts at the channel on which the link was found. It advances by one every SLOT_LEN cycles, wraps after NUM_CHAN-1, and changes at no other time.
- R9: In sync or idle, LOSS_SLOTS consecutive hop slots with no received packet return the block to locate with channel index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| isMaster | input | 1 | Role: 1 master, 0 slave; held stable outside reset |
| txValid | output | 1 | Packet send request |
| txReady | input | 1 | Radio accepts the request this cycle |
| txKind | output | 2 | Kind of the requested packet: 0 search, 1 acknowledge, 2 start, 3 data |
| txCount | output | CNT_W | Countdown carried by a start packet |
| rxValid | input | 1 | One-cycle pulse: a valid packet arrived from the peer |
| rxKind | input | 2 | Kind of the received packet |
| rxCount | input | CNT_W | Countdown field of a received start packet |
| chanIdx | output | IDX_W | Index into the shared channel table |
| linkPhase | output | 2 | 0 locate, 1 sync, 2 idle |

## Verification
The master is first run with no peer. Its accepted searches must step through every channel exactly once, at a fixed spacing, and then wrap. This separates a correct per-channel window from an early or late advance. An acknowledge is injected on one channel after a data packet has been ignored there. The test then times the countdown, five hops that cross the wrap, and a silence that must end the link after exactly the loss run, which exposes off-by-one errors in the slot and miss counters. The slave is tested for its dwell time, for ignoring kinds other than search, for holding its acknowledge while ready is low, for a countdown of two against a countdown of zero, and for losing the link while it waits for a start that never arrives.

// File: rtl/linkSeekPkg.sv
package linkSeekPkg;

  typedef enum logic [1:0] {
    PK_SEARCH = 2'd0,
    PK_ACK    = 2'd1,
    PK_START  = 2'd2,
    PK_DATA   = 2'd3
  } pktKind_e;

  typedef enum logic [1:0] {
    PH_LOCATE = 2'd0,
    PH_SYNC   = 2'd1,
    PH_IDLE   = 2'd2
  } linkPhase_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic winClear;
    logic chanNext;
    logic chanClear;
    logic slotRestart;
    logic cntLoadOwn;
    logic cntLoadRx;
    logic missRun;
    logic missClear;
  } ctrlStrobe_t;

endpackage

// File: rtl/linkSeekTimers.sv
module linkSeekTimers
  import linkSeekPkg::*;
#(
  parameter int NUM_CHAN    = 8,
  parameter int ACK_WAIT    = 15,
  parameter int SLAVE_DWELL = 160,
  parameter int SLOT_LEN    = 32,
  parameter int START_SLOTS = 4,
  parameter int LOSS_SLOTS  = 16,
  parameter int CNT_W       = 4,
  localparam int IDX_W      = $clog2(NUM_CHAN),
  localparam int WIN_MAX    = (ACK_WAIT > SLAVE_DWELL) ? ACK_WAIT : SLAVE_DWELL,
  localparam int WIN_W      = $clog2(WIN_MAX + 1),
  localparam int SLOT_W     = $clog2(SLOT_LEN + 1),
  localparam int MISS_W     = $clog2(LOSS_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              isMaster,
  input  ctrlStrobe_t       stb,
  input  logic              rxValid,
  input  logic [CNT_W-1:0]  rxCount,
  output logic [IDX_W-1:0]  chanIdx,
  output logic              winDone,
  output logic              slotTick,
  output logic              cntLast,
  output logic              lost
);

  logic [WIN_W-1:0]  winCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic [CNT_W-1:0]  cntVal;
  logic [MISS_W-1:0] missCnt;
  logic              rxSeen;
  logic              heardThisSlot;
  logic [WIN_W-1:0]  winLimit;

  assign winLimit      = isMaster ? WIN_W'(ACK_WAIT - 1) : WIN_W'(SLAVE_DWELL - 1);
  assign winDone       = (winCnt == winLimit);
  assign slotTick      = (slotCnt == SLOT_W'(SLOT_LEN - 1));
  assign cntLast       = (cntVal == CNT_W'(1));
  assign heardThisSlot = rxSeen | rxValid;
  assign lost          = stb.missRun & slotTick & ~heardThisSlot &
                         (missCnt == MISS_W'(LOSS_SLOTS - 1));

  // per-channel window timer, saturating at its limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            winCnt <= '0;
    else if (stb.winClear) winCnt <= '0;
    else if (!winDone)     winCnt <= winCnt + WIN_W'(1);
  end

  // channel index into the shared table
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             chanIdx <= '0;
    else if (stb.chanClear) chanIdx <= '0;
    else if (stb.chanNext)  chanIdx <= (chanIdx == IDX_W'(NUM_CHAN - 1)) ? '0 : chanIdx + IDX_W'(1);
  end

  // hop slot timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          slotCnt <= '0;
    else if (stb.slotRestart || slotTick) slotCnt <= '0;
    else                                 slotCnt <= slotCnt + SLOT_W'(1);
  end

  // start countdown in hop slots
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cntVal <= '0;
    else if (stb.cntLoadOwn)            cntVal <= CNT_W'(START_SLOTS);
    else if (stb.cntLoadRx)             cntVal <= rxCount;
    else if (slotTick && cntVal != '0)  cntVal <= cntVal - CNT_W'(1);
  end

  // peer activity within the current slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rxSeen <= 1'b0;
    else if (stb.missClear) rxSeen <= 1'b0;
    else if (slotTick)      rxSeen <= 1'b0;
    else if (rxValid)       rxSeen <= 1'b1;
  end

  // run of silent slots
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         missCnt <= '0;
    else if (stb.missClear)             missCnt <= '0;
    else if (stb.missRun && slotTick)   missCnt <= heardThisSlot ? '0 : missCnt + MISS_W'(1);
  end

  // control must clear the run when it declares the link lost
  assert_miss_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    missCnt < MISS_W'(LOSS_SLOTS));

  // control never asks for two countdown sources at once
  assert_one_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.cntLoadOwn, stb.cntLoadRx}));

endmodule

// File: rtl/linkSeekCtrl.sv
module linkSeekCtrl
  import linkSeekPkg::*;
#(
  parameter int START_SLOTS = 4,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             isMaster,
  input  logic             txReady,
  input  logic             rxValid,
  input  logic [1:0]       rxKind,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             winDone,
  input  logic             slotTick,
  input  logic             cntLast,
  input  logic             lost,
  output ctrlStrobe_t      stb,
  output logic             txValid,
  output logic [1:0]       txKind,
  output logic [CNT_W-1:0] txCount,
  output logic [1:0]       linkPhase
);

  typedef enum logic [2:0] {
    S_SEND, S_WAIT, S_LISTEN, S_ACK, S_START_TX, S_START_RX, S_COUNT, S_HOP
  } seqState_e;

  seqState_e state, nextState;
  seqState_e locateEntry;

  assign locateEntry = isMaster ? S_SEND : S_LISTEN;
  assign txCount     = CNT_W'(START_SLOTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= isMaster ? S_SEND : S_LISTEN;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    txValid   = 1'b0;
    txKind    = PK_SEARCH;
    unique case (state)
      S_SEND: begin
        txValid = 1'b1;
        txKind  = PK_SEARCH;
        if (txReady) begin
          nextState    = S_WAIT;
          stb.winClear = 1'b1;
        end
      end
      S_WAIT: begin
        if (rxValid && rxKind == PK_ACK) begin
          nextState       = S_START_TX;
          stb.slotRestart = 1'b1;
          stb.missClear   = 1'b1;
        end else if (winDone) begin
          nextState    = S_SEND;
          stb.chanNext = 1'b1;
        end
      end
      S_LISTEN: begin
        if (rxValid && rxKind == PK_SEARCH) begin
          nextState = S_ACK;
        end else if (winDone) begin
          stb.chanNext = 1'b1;
          stb.winClear = 1'b1;
        end
      end
      S_ACK: begin
        txValid = 1'b1;
        txKind  = PK_ACK;
        if (txReady) begin
          nextState       = S_START_RX;
          stb.slotRestart = 1'b1;
          stb.missClear   = 1'b1;
        end
      end
      S_START_TX: begin
        stb.missRun = 1'b1;
        txValid     = !lost;
        txKind      = PK_START;
        if (lost) begin
          nextState = locateEntry;
        end else if (txReady) begin
          nextState       = S_COUNT;
          stb.cntLoadOwn  = 1'b1;
          stb.slotRestart = 1'b1;
        end
      end
      S_START_RX: begin
        stb.missRun = 1'b1;
        if (lost) begin
          nextState = locateEntry;
        end else if (rxValid && rxKind == PK_START) begin
          stb.slotRestart = 1'b1;
          if (rxCount == '0) nextState = S_HOP;
          else begin
            nextState     = S_COUNT;
            stb.cntLoadRx = 1'b1;
          end
        end
      end
      S_COUNT: begin
        stb.missRun = 1'b1;
        if (lost)                     nextState = locateEntry;
        else if (slotTick && cntLast) nextState = S_HOP;
      end
      S_HOP: begin
        stb.missRun = 1'b1;
        if (lost)          nextState    = locateEntry;
        else if (slotTick) stb.chanNext = 1'b1;
      end
      default: nextState = locateEntry;
    endcase
    if (lost) begin
      stb.chanClear = 1'b1;
      stb.winClear  = 1'b1;
      stb.missClear = 1'b1;
    end
  end

  always_comb begin
    unique case (state)
      S_START_TX, S_START_RX, S_COUNT: linkPhase = PH_SYNC;
      S_HOP:                           linkPhase = PH_IDLE;
      default:                         linkPhase = PH_LOCATE;
    endcase
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && !txReady && !lost) |=> (txValid && $stable(txKind)));

  assert_slave_no_search_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!isMaster && txValid) |-> (txKind == PK_ACK));

  assert_idle_from_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (linkPhase == PH_IDLE && $past(linkPhase) != PH_IDLE) |-> ($past(linkPhase) == PH_SYNC));

endmodule

// File: rtl/linkSeek.sv
module linkSeek
  import linkSeekPkg::*;
#(
  parameter int NUM_CHAN    = 8,
  parameter int ACK_WAIT    = 15,
  parameter int SLAVE_DWELL = 160,
  parameter int SLOT_LEN    = 32,
  parameter int START_SLOTS = 4,
  parameter int LOSS_SLOTS  = 16,
  parameter int CNT_W       = 4,
  localparam int IDX_W      = $clog2(NUM_CHAN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             isMaster,
  output logic             txValid,
  input  logic             txReady,
  output logic [1:0]       txKind,
  output logic [CNT_W-1:0] txCount,
  input  logic             rxValid,
  input  logic [1:0]       rxKind,
  input  logic [CNT_W-1:0] rxCount,
  output logic [IDX_W-1:0] chanIdx,
  output logic [1:0]       linkPhase
);

  // elaboration checks on the parameter set
  if (SLAVE_DWELL <= NUM_CHAN * (ACK_WAIT + 1)) begin : gDwellTooShort
    $error("slave dwell must exceed the master sweep time");
  end
  if (NUM_CHAN < 2) begin : gTooFewChannels
    $error("at least two channels are needed");
  end
  if (START_SLOTS < 1 || START_SLOTS >= (1 << CNT_W)) begin : gBadStart
    $error("start countdown must be nonzero and fit its field");
  end
  if (START_SLOTS + 1 >= LOSS_SLOTS) begin : gStartVsLoss
    $error("start countdown must end before the loss run");
  end

  ctrlStrobe_t stb;
  logic        winDone;
  logic        slotTick;
  logic        cntLast;
  logic        lost;

  linkSeekCtrl #(
    .START_SLOTS (START_SLOTS),
    .CNT_W       (CNT_W)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .isMaster  (isMaster),
    .txReady   (txReady),
    .rxValid   (rxValid),
    .rxKind    (rxKind),
    .rxCount   (rxCount),
    .winDone   (winDone),
    .slotTick  (slotTick),
    .cntLast   (cntLast),
    .lost      (lost),
    .stb       (stb),
    .txValid   (txValid),
    .txKind    (txKind),
    .txCount   (txCount),
    .linkPhase (linkPhase)
  );

  linkSeekTimers #(
    .NUM_CHAN    (NUM_CHAN),
    .ACK_WAIT    (ACK_WAIT),
    .SLAVE_DWELL (SLAVE_DWELL),
    .SLOT_LEN    (SLOT_LEN),
    .START_SLOTS (START_SLOTS),
    .LOSS_SLOTS  (LOSS_SLOTS),
    .CNT_W       (CNT_W)
  ) timers_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .isMaster (isMaster),
    .stb      (stb),
    .rxValid  (rxValid),
    .rxCount  (rxCount),
    .chanIdx  (chanIdx),
    .winDone  (winDone),
    .slotTick (slotTick),
    .cntLast  (cntLast),
    .lost     (lost)
  );

  // a pending request keeps its channel
  assert_chan_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && !txReady && !lost) |=> $stable(chanIdx));

  // in idle the channel moves only on a slot boundary
  assert_hop_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (linkPhase == PH_IDLE && !slotTick) |=> $stable(chanIdx));

endmodule

// File: tb/linkSeek_tb_top.sv
`timescale 1ns/1ps
module linkSeek_tb_top;

  localparam int NCH   = 8;
  localparam int AWAIT = 15;
  localparam int DWELL = 160;
  localparam int SLOT  = 32;
  localparam int START = 4;
  localparam int LOSS  = 16;
  localparam int CW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic isMaster = 1'b1;
  logic txValid, txReady = 1'b0;
  logic [1:0] txKind;
  logic [CW-1:0] txCount;
  logic rxValid = 1'b0;
  logic [1:0] rxKind = 2'd0;
  logic [CW-1:0] rxCount = '0;
  logic [2:0] chanIdx;
  logic [1:0] linkPhase;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  linkSeek dut_i (
    .clk(clk), .rst_n(rst_n), .isMaster(isMaster),
    .txValid(txValid), .txReady(txReady), .txKind(txKind), .txCount(txCount),
    .rxValid(rxValid), .rxKind(rxKind), .rxCount(rxCount),
    .chanIdx(chanIdx), .linkPhase(linkPhase)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic role, input logic rdy);
    @(negedge clk);
    rst_n = 1'b0; isMaster = role; txReady = rdy; rxValid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulseRx(input logic [1:0] kind, input int count);
    rxKind = kind; rxCount = CW'(count); rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic waitPhase(input int ph, input int limit, input string tag, output int edgeAt);
    edgeAt = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (linkPhase == 2'(ph)) begin edgeAt = cyc; break; end
    end
    if (edgeAt < 0) chk({tag, " phase reached"}, int'(linkPhase), ph);
  endtask

  task automatic waitChanChange(input int limit, input string tag, output int edgeAt);
    logic [2:0] startChan;
    startChan = chanIdx;
    edgeAt = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (chanIdx != startChan) begin edgeAt = cyc; break; end
    end
    if (edgeAt < 0) chk({tag, " channel moved"}, 0, 1);
  endtask

  // R1: state held in and just after reset, both roles
  task automatic testReset();
    doReset(1'b1, 1'b0);
    chk("R1 master phase", int'(linkPhase), 0);
    chk("R1 master chan", int'(chanIdx), 0);
    chk("R1 master req", int'(txValid), 1);
    chk("R1 master kind", int'(txKind), 0);
    doReset(1'b0, 1'b0);
    @(negedge clk);
    chk("R1 slave phase", int'(linkPhase), 0);
    chk("R1 slave req", int'(txValid), 0);
  endtask

  // R2: master sweep with no peer
  task automatic testMasterSweep();
    int hsEdge[9];
    int got = 0;
    doReset(1'b1, 1'b1);
    for (int i = 0; i < 9 * (AWAIT + 1) + 20 && got < 9; i++) begin
      if (txValid && txReady) begin
        chk("R2 search kind", int'(txKind), 0);
        chk("R2 search chan", int'(chanIdx), got % NCH);
        hsEdge[got] = cyc + 1;
        got++;
      end
      @(negedge clk);
    end
    chk("R2 search count", got, 9);
    for (int k = 1; k < 9; k++)
      chk("R2 search spacing", hsEdge[k] - hsEdge[k-1], AWAIT + 1);
  endtask

  // R5, R6, R8, R9: master link, countdown, hopping, loss
  task automatic testMasterLink();
    int hs, idleAt, prev, e;
    bit found = 1'b0;
    doReset(1'b1, 1'b1);
    for (int i = 0; i < 200 && !found; i++) begin
      @(negedge clk);
      if (!txValid && chanIdx == 3'd3 && linkPhase == 2'd0) found = 1'b1;
    end
    chk("R5 reached wait on chan 3", int'(found), 1);
    pulseRx(2'd3, 0);
    chk("R5 data ignored in locate", int'(linkPhase), 0);
    pulseRx(2'd1, 0);
    chk("R5 ack gives sync", int'(linkPhase), 1);
    chk("R5 chan kept", int'(chanIdx), 3);
    chk("R6 start req", int'(txValid), 1);
    chk("R6 start kind", int'(txKind), 2);
    chk("R6 start count", int'(txCount), START);
    hs = cyc + 1;
    waitPhase(2, START * SLOT + 10, "R6", idleAt);
    chk("R6 countdown length", idleAt - hs, START * SLOT);
    chk("R8 first hop chan", int'(chanIdx), 3);
    prev = idleAt;
    for (int s = 0; s < 5; s++) begin
      repeat (SLOT / 2) @(negedge clk);
      pulseRx(2'd3, 0);
      waitChanChange(SLOT + 4, "R8", e);
      chk("R8 hop chan", int'(chanIdx), (4 + s) % NCH);
      chk("R8 hop period", e - prev, SLOT);
      prev = e;
    end
    waitPhase(0, (LOSS + 2) * SLOT, "R9", e);
    chk("R9 loss time", e - prev, LOSS * SLOT);
    chk("R9 chan reset", int'(chanIdx), 0);
    chk("R9 search resumes", int'(txValid), 1);
  endtask

  // R3, R4, R7: slave dwell, acknowledge handshake, countdown of two
  task automatic testSlaveLink();
    int c1, c2, r, e;
    doReset(1'b0, 1'b0);
    waitChanChange(DWELL + 10, "R3", c1);
    waitChanChange(DWELL + 10, "R3", c2);
    chk("R3 dwell length", c2 - c1, DWELL);
    chk("R3 chan after two dwells", int'(chanIdx), 2);
    pulseRx(2'd1, 0);
    chk("R4 ack kind ignored req", int'(txValid), 0);
    chk("R4 ack kind ignored phase", int'(linkPhase), 0);
    pulseRx(2'd0, 0);
    chk("R4 ack req", int'(txValid), 1);
    chk("R4 ack kind", int'(txKind), 1);
    chk("R4 ack chan", int'(chanIdx), 2);
    repeat (3) @(negedge clk);
    chk("R4 ack held", int'(txValid), 1);
    chk("R4 phase while held", int'(linkPhase), 0);
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
    chk("R4 sync after accept", int'(linkPhase), 1);
    chk("R4 req dropped", int'(txValid), 0);
    r = cyc + 1;
    pulseRx(2'd2, 2);
    waitPhase(2, 3 * SLOT, "R7", e);
    chk("R7 countdown two", e - r, 2 * SLOT);
    chk("R7 chan at idle", int'(chanIdx), 2);
  endtask

  // R7: countdown of zero
  task automatic testSlaveZero();
    doReset(1'b0, 1'b1);
    pulseRx(2'd0, 0);
    @(negedge clk);
    chk("R7 sync before start", int'(linkPhase), 1);
    pulseRx(2'd2, 0);
    chk("R7 zero count idle", int'(linkPhase), 2);
  endtask

  // R9: slave never gets a start
  task automatic testSlaveSyncLoss();
    int a, e;
    doReset(1'b0, 1'b1);
    pulseRx(2'd0, 0);
    @(negedge clk);
    a = cyc;
    chk("R9 slave in sync", int'(linkPhase), 1);
    waitPhase(0, (LOSS + 2) * SLOT, "R9", e);
    chk("R9 sync loss time", e - a, LOSS * SLOT);
    chk("R9 sync loss chan", int'(chanIdx), 0);
  endtask

  initial begin
    testReset();
    testMasterSweep();
    testMasterLink();
    testSlaveLink();
    testSlaveZero();
    testSlaveSyncLoss();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule